// File: doc/BRIEF.md
# Clock Generator Mode Controller

This block decides which clock source is driving the system clock output of a clock generator. Software writes a 2-bit requested mode. The block reports the mode that is actually in force on a separate 2-bit status output. The actual mode moves to the request only after a short synchronisation delay, and only if the clock sources that the target mode needs are reported stable. The oscillator, the digitally controlled oscillator (DCO) and the frequency-locked loop (FLL) arithmetic are outside this block. They appear only as status inputs.

For the mode in force, the block also produces three things:
- the length of the frequency-comparison window, and whether that window is counted in internal or external reference cycles;
- the divider phase, which is a halved output while the loop is acquiring lock and a full output once it is locked;
- the select for the fixed-frequency peripheral clock.

If the external clock is lost while the FLL is engaged on the external reference, the block falls back to the self-clocked mode at once and raises a sticky flag.

Mode codes are `00` self-clocked (SELF), `01` FLL on internal reference (INT_FLL), `10` FLL bypassed on external clock (EXT_BYP) and `11` FLL on external reference (EXT_FLL).

The synchroniser has two named states:
- **HOLD** (idle). A request that differs from the actual mode and is permitted starts a sync. This is the *start* transition.
- **SYNC** (counting). It has four transitions:
  - *restart*: the request changed to another permitted mode, so the count begins again.
  - *abort*: the request was withdrawn, or the needed source became unstable, so the controller returns to HOLD.
  - *commit*: the count is complete, so the actual mode takes the target and the controller returns to HOLD.
  - *fallback*: the clock was lost while in EXT_FLL, so the controller goes to SELF and HOLD. This transition can be taken from either state.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: After reset the actual mode is `01`, the divider-halved output is 1, the loss flag is 0, the fixed-clock select is 0 and the window length is 8.
- R2: A permitted request that differs from the actual mode and is held steady changes the actual mode on the 4th rising edge that sees it, counting the first edge that sees it. A change of the request to another permitted mode during the count restarts the count.
- R3: Entry to `01` requires DCO-stable. Entry to `10` requires external-stable. Entry to `11` requires both. While the condition is false, the actual mode is unchanged.
- R4: A request for `00` while the actual mode is `10` is never honoured, and the actual mode stays `10`.
- R5: The window output is 8 cycles on the internal reference (`win_ext`=0) in modes `00` and `01`. In mode `11` it is 2 external cycles when range is 0 and 128 external cycles when range is 1 (`win_ext`=1). In mode `10` it is 0.
- R6: In modes `01` and `11`, `div_half` is 1 until a clock edge sees lock. It is 0 from that edge on. A multiplier-change pulse returns it to 1. In modes `00` and `10` it is 0.
- R7: `fix_ext` is 1 only in mode `11` with lock=1 and the ratio flag ((P·N)/R ≥ 4) set. Otherwise it is 0, which selects the bus clock.
- R8: When clock loss is seen in mode `11`, the next edge makes the actual mode `00` and sets `loss_flag`. The flag stays set until an edge with `loss_clr`=1.
- R9: If the needed source becomes unstable during a count, the pending change is dropped. Counting begins again from the first edge at which the source is stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_mode | input | 2 | Requested mode |
| ext_stable | input | 1 | External clock is stable |
| dco_stable | input | 1 | DCO output is stable |
| lock | input | 1 | FLL reports lock |
| clk_loss | input | 1 | External clock loss detected |
| range_hi | input | 1 | External reference range select |
| ratio_ge4 | input | 1 | (P·N)/R is at least 4 |
| mult_wr | input | 1 | Multiplier was rewritten (re-lock) |
| loss_clr | input | 1 | Write-one-to-clear for loss flag |
| act_mode | output | 2 | Actual mode in force |
| win_len | output | 8 | Comparison window length in reference cycles |
| win_ext | output | 1 | Window counted on external reference |
| div_half | output | 1 | Output divider in locking (halved) phase |
| fix_ext | output | 1 | Fixed clock selects external/2 |
| loss_flag | output | 1 | Sticky clock-loss fallback flag |

## Verification
The bench builds the block with its default parameters: a 4-edge synchroniser and windows of 8, 2 and 128 cycles. With a 4-edge sync, the bench can sample on the edge just before a mode change and on the edge of the change itself. It can also place a restart or a stability drop in the middle of a count, and show that the result differs from an unrestarted count. The small windows let the range and mode dependence of the window be read directly from the port after each mode change.

// File: rtl/clkgen_mode_pkg.sv
package clkgen_mode_pkg;
    typedef enum logic [1:0] {
        MODE_SELF    = 2'b00,
        MODE_INT_FLL = 2'b01,
        MODE_EXT_BYP = 2'b10,
        MODE_EXT_FLL = 2'b11
    } clk_mode_e;

    typedef enum logic {
        ST_HOLD = 1'b0,
        ST_SYNC = 1'b1
    } sync_st_e;
endpackage

// File: rtl/clkgen_mode_fsm.sv
module clkgen_mode_fsm
    import clkgen_mode_pkg::*;
#(
    parameter int SYNC_CYCLES = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  clk_mode_e req,
    input  logic      ext_stable,
    input  logic      dco_stable,
    input  logic      clk_loss,
    input  logic      loss_clr,
    output clk_mode_e act,
    output logic      loss_flag
);
    localparam int CNT_W = $clog2(SYNC_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SYNC_CYCLES - 1);

    sync_st_e         st_q, st_d;
    clk_mode_e        act_q, act_d, tgt_q, tgt_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             flag_q, flag_d;
    logic             req_ok, fall;

    function automatic logic entry_ok(clk_mode_e tgt, clk_mode_e cur,
                                      logic ext, logic dco);
        logic ok;
        unique case (tgt)
            MODE_SELF:    ok = (cur != MODE_EXT_BYP);
            MODE_INT_FLL: ok = dco;
            MODE_EXT_BYP: ok = ext;
            MODE_EXT_FLL: ok = ext && dco;
        endcase
        return ok;
    endfunction

    assign req_ok = entry_ok(req, act_q, ext_stable, dco_stable);
    assign fall   = (act_q == MODE_EXT_FLL) && clk_loss;

    always_comb begin
        st_d   = st_q;
        act_d  = act_q;
        tgt_d  = tgt_q;
        cnt_d  = cnt_q;
        flag_d = loss_clr ? 1'b0 : flag_q;
        if (fall) begin
            act_d  = MODE_SELF;
            st_d   = ST_HOLD;
            cnt_d  = '0;
            flag_d = 1'b1;
        end else begin
            unique case (st_q)
                ST_HOLD: begin
                    if (req != act_q && req_ok) begin
                        st_d  = ST_SYNC;
                        tgt_d = req;
                        cnt_d = CNT_W'(1);
                    end
                end
                ST_SYNC: begin
                    if (req == act_q || !req_ok) begin
                        st_d  = ST_HOLD;
                        cnt_d = '0;
                    end else if (req != tgt_q) begin
                        tgt_d = req;
                        cnt_d = CNT_W'(1);
                    end else if (cnt_q == CNT_LAST) begin
                        act_d = tgt_q;
                        st_d  = ST_HOLD;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_HOLD;
            act_q  <= MODE_INT_FLL;
            tgt_q  <= MODE_INT_FLL;
            cnt_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            act_q  <= act_d;
            tgt_q  <= tgt_d;
            cnt_q  <= cnt_d;
            flag_q <= flag_d;
        end
    end

    always_comb begin
        act       = act_q;
        loss_flag = flag_q;
    end

    // R2: the actual mode only moves out of a sync run or a loss fallback
    a_r2_change_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q != $past(act_q)) |->
            ($past(st_q) == ST_SYNC || $past(act_q) == MODE_EXT_FLL));

    // R3: entry conditions on the sources
    a_r3_int_needs_dco: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == MODE_INT_FLL && $past(act_q) != MODE_INT_FLL) |-> $past(dco_stable));
    a_r3_byp_needs_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == MODE_EXT_BYP && $past(act_q) != MODE_EXT_BYP) |-> $past(ext_stable));
    a_r3_fll_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == MODE_EXT_FLL && $past(act_q) != MODE_EXT_FLL) |->
            ($past(ext_stable) && $past(dco_stable)));

    // R4: bypass never drops directly to self-clocked
    a_r4_no_byp_to_self: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == MODE_EXT_BYP) |=> (act_q != MODE_SELF));

    // R8: loss in external FLL mode forces self-clocked and sets the flag
    a_r8_loss_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == MODE_EXT_FLL && clk_loss) |=> (act_q == MODE_SELF && flag_q));
endmodule

// File: rtl/clkgen_lock_phase.sv
module clkgen_lock_phase (
    input  logic clk,
    input  logic rst_n,
    input  logic lock,
    input  logic mult_wr,
    output logic locked
);
    logic locked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       locked_q <= 1'b0;
        else if (mult_wr) locked_q <= 1'b0;
        else if (lock)    locked_q <= 1'b1;
    end

    assign locked = locked_q;

    // R6: a multiplier rewrite always puts the divider back into its locking phase
    a_r6_relock_on_mult: assert property (@(posedge clk) disable iff (!rst_n)
        mult_wr |=> !locked_q);
endmodule

// File: rtl/clkgen_out_decode.sv
module clkgen_out_decode
    import clkgen_mode_pkg::*;
#(
    parameter int WIN_W      = 8,
    parameter int INT_WIN    = 8,
    parameter int EXT_WIN_LO = 2,
    parameter int EXT_WIN_HI = 128
) (
    input  clk_mode_e        act,
    input  logic             range_hi,
    input  logic             lock,
    input  logic             ratio_ge4,
    input  logic             locked,
    output logic [WIN_W-1:0] win_len,
    output logic             win_ext,
    output logic             div_half,
    output logic             fix_ext
);
    always_comb begin
        win_len  = '0;
        win_ext  = 1'b0;
        div_half = 1'b0;
        fix_ext  = 1'b0;
        unique case (act)
            MODE_SELF: begin
                win_len = WIN_W'(INT_WIN);
            end
            MODE_INT_FLL: begin
                win_len  = WIN_W'(INT_WIN);
                div_half = !locked;
            end
            MODE_EXT_BYP: begin
                win_len = '0;
            end
            MODE_EXT_FLL: begin
                win_ext  = 1'b1;
                win_len  = range_hi ? WIN_W'(EXT_WIN_HI) : WIN_W'(EXT_WIN_LO);
                div_half = !locked;
                fix_ext  = lock && ratio_ge4;
            end
        endcase
    end

    // R7: the external fixed clock is only chosen with the FLL on the external reference
    a_r7_fix_only_ext_fll: assert property (@(posedge fix_ext) act == MODE_EXT_FLL);
endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
    import clkgen_mode_pkg::*;
#(
    parameter int SYNC_CYCLES = 4,
    parameter int WIN_W       = 8,
    parameter int INT_WIN     = 8,
    parameter int EXT_WIN_LO  = 2,
    parameter int EXT_WIN_HI  = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       req_mode,
    input  logic             ext_stable,
    input  logic             dco_stable,
    input  logic             lock,
    input  logic             clk_loss,
    input  logic             range_hi,
    input  logic             ratio_ge4,
    input  logic             mult_wr,
    input  logic             loss_clr,
    output logic [1:0]       act_mode,
    output logic [WIN_W-1:0] win_len,
    output logic             win_ext,
    output logic             div_half,
    output logic             fix_ext,
    output logic             loss_flag
);
    clk_mode_e act;
    logic      locked;

    clkgen_mode_fsm #(.SYNC_CYCLES(SYNC_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (clk_mode_e'(req_mode)),
        .ext_stable (ext_stable),
        .dco_stable (dco_stable),
        .clk_loss   (clk_loss),
        .loss_clr   (loss_clr),
        .act        (act),
        .loss_flag  (loss_flag)
    );

    clkgen_lock_phase u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (lock),
        .mult_wr (mult_wr),
        .locked  (locked)
    );

    clkgen_out_decode #(
        .WIN_W      (WIN_W),
        .INT_WIN    (INT_WIN),
        .EXT_WIN_LO (EXT_WIN_LO),
        .EXT_WIN_HI (EXT_WIN_HI)
    ) u_dec (
        .act       (act),
        .range_hi  (range_hi),
        .lock      (lock),
        .ratio_ge4 (ratio_ge4),
        .locked    (locked),
        .win_len   (win_len),
        .win_ext   (win_ext),
        .div_half  (div_half),
        .fix_ext   (fix_ext)
    );

    assign act_mode = act;
endmodule

// File: tb/clkgen_mode_ctrl_bench.sv
`timescale 1ns/1ps
module clkgen_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req_mode = 2'b01;
    logic       ext_stable = 1'b0, dco_stable = 1'b0, lock = 1'b0, clk_loss = 1'b0;
    logic       range_hi = 1'b0, ratio_ge4 = 1'b0, mult_wr = 1'b0, loss_clr = 1'b0;
    logic [1:0] act_mode;
    logic [7:0] win_len;
    logic       win_ext, div_half, fix_ext, loss_flag;

    int  n_chk = 0;
    int  n_bad = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    clkgen_mode_ctrl u_clkgen_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .ext_stable(ext_stable),
        .dco_stable(dco_stable), .lock(lock), .clk_loss(clk_loss), .range_hi(range_hi),
        .ratio_ge4(ratio_ge4), .mult_wr(mult_wr), .loss_clr(loss_clr),
        .act_mode(act_mode), .win_len(win_len), .win_ext(win_ext),
        .div_half(div_half), .fix_ext(fix_ext), .loss_flag(loss_flag)
    );

    // {req, ext_stable, dco_stable, range_hi, expected act, expected window}
    localparam logic [14:0] VEC [0:9] = '{
        {2'b01, 1'b0, 1'b1, 1'b0, 2'b01, 8'd8},    // R3 int FLL held
        {2'b00, 1'b0, 1'b1, 1'b0, 2'b00, 8'd8},    // R2 to self
        {2'b10, 1'b0, 1'b1, 1'b0, 2'b00, 8'd8},    // R3 bypass refused, ext unstable
        {2'b10, 1'b1, 1'b1, 1'b0, 2'b10, 8'd0},    // R3 bypass entered
        {2'b00, 1'b1, 1'b1, 1'b0, 2'b10, 8'd0},    // R4 bypass to self refused
        {2'b11, 1'b1, 1'b0, 1'b0, 2'b10, 8'd0},    // R3 ext FLL refused, dco unstable
        {2'b11, 1'b1, 1'b1, 1'b0, 2'b11, 8'd2},    // R5 ext FLL, range 0
        {2'b11, 1'b1, 1'b1, 1'b1, 2'b11, 8'd128},  // R5 ext FLL, range 1
        {2'b01, 1'b1, 1'b1, 1'b1, 2'b01, 8'd8},    // R5 int FLL window
        {2'b11, 1'b0, 1'b1, 1'b0, 2'b01, 8'd8}     // R3 ext FLL refused, ext unstable
    };

    task automatic chk(input string tag, input int actual, input int expected);
        n_chk++;
        if (actual !== expected) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #9 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 act", act_mode, 1);
        chk("R1 div_half", div_half, 1);
        chk("R1 loss_flag", loss_flag, 0);
        chk("R1 fix_ext", fix_ext, 0);
        chk("R1 win_len", win_len, 8);

        for (int i = 0; i < 10; i++) begin
            {req_mode, ext_stable, dco_stable, range_hi} = VEC[i][14:10];
            edges(4);
            chk($sformatf("vec%0d act", i), act_mode, int'(VEC[i][9:8]));
            chk($sformatf("vec%0d win", i), win_len, int'(VEC[i][7:0]));
        end
        chk("R5 win_ext int", win_ext, 0);

        // R2 exact timing: 01 -> 00
        req_mode = 2'b00;
        edges(3);
        chk("R2 before 4th edge", act_mode, 1);
        edges(1);
        chk("R2 on 4th edge", act_mode, 0);

        // R2 restart: request changes mid-count
        ext_stable = 1'b1; dco_stable = 1'b1;
        req_mode = 2'b01;
        edges(2);
        req_mode = 2'b10;
        edges(3);
        chk("R2 restarted count", act_mode, 0);
        edges(1);
        chk("R2 after restart", act_mode, 2);

        // R7 fixed select stays on bus clock in bypass
        lock = 1'b1; ratio_ge4 = 1'b1;
        edges(1);
        chk("R7 bypass fix_ext", fix_ext, 0);
        chk("R6 bypass div_half", div_half, 0);
        lock = 1'b0; ratio_ge4 = 1'b0;
        mult_wr = 1'b1;
        edges(1);
        mult_wr = 1'b0;

        // R9 stability drop during count
        req_mode = 2'b11;
        edges(2);
        dco_stable = 1'b0;
        edges(4);
        chk("R9 aborted", act_mode, 2);
        dco_stable = 1'b1;
        edges(4);
        chk("R9 re-entered", act_mode, 3);
        chk("R5 win_ext ext", win_ext, 1);

        // R6 / R7 lock phase and fixed select
        chk("R6 div_half unlocked", div_half, 1);
        lock = 1'b1; ratio_ge4 = 1'b1;
        edges(1);
        chk("R6 div_half locked", div_half, 0);
        chk("R7 fix_ext on", fix_ext, 1);
        ratio_ge4 = 1'b0;
        edges(1);
        chk("R7 fix_ext ratio low", fix_ext, 0);
        mult_wr = 1'b1;
        edges(1);
        chk("R6 relock after mult", div_half, 1);
        mult_wr = 1'b0;
        edges(1);
        chk("R6 locked again", div_half, 0);

        // R8 loss fallback and sticky flag
        clk_loss = 1'b1; req_mode = 2'b00;
        edges(1);
        chk("R8 fallback act", act_mode, 0);
        chk("R8 flag set", loss_flag, 1);
        clk_loss = 1'b0;
        edges(3);
        chk("R8 flag sticky", loss_flag, 1);
        loss_clr = 1'b1;
        edges(1);
        loss_clr = 1'b0;
        chk("R8 flag cleared", loss_flag, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule